// File: doc/BRIEF.md
# Configurable Synchronous Serial Shift Port

This block is an 8-bit synchronous serial port for a small microcontroller. One shift register serves both directions. In exchange mode, every bit presented on the data output is paired with one bit captured from the data input. In receive-only mode, the data output is frozen while eight bits are collected. Software chooses at run time whether the least or the most significant bit goes first.

The shift clock has two possible sources. It can be made inside the block by dividing the system clock, with four selectable rates, and driven out on the clock pin. It can also be taken from an external master through the clock pin, which a two-flop synchroniser brings into the system clock domain. The rest of the chip loads a transmit byte, pulses start, watches a busy flag and a done flag, reads the received byte, and receives a one-cycle completion interrupt request.

Configuration and the transmit byte are captured when a transfer starts. Data out changes on falling shift-clock edges. Data in is sampled on rising edges.

Top module: `serial_shift_port`

## Requirements
- R1: After reset, busy, done and irq are 0, sck_out is 1, sck_oe is 1 and so is 0.
- R2: A start pulse while idle sets busy in the next cycle and clears done. Busy stays set through exactly 8 falling and 8 rising shift-clock edges. At the eighth rising edge, busy clears, done sets, and irq is high for exactly one cycle.
- R3: In exchange mode (cfg_rx_only=0), each of the 8 falling edges puts one transmit bit on so. Each of the 8 rising edges captures si. After completion, rx_data holds the 8 captured bits.
- R4: With cfg_lsb_first=1, bit 0 is sent and received first and bit 7 last. With cfg_lsb_first=0, the order is reversed.
- R5: so changes only on a falling edge of the shift clock.
- R6: In receive-only mode (cfg_rx_only=1), so keeps the value it had before start for the whole transfer, while 8 bits from si still arrive in rx_data.
- R7: With the internal clock (cfg_ext_clk=0), sck_oe is 1 and each half period of sck_out lasts DIV_BASE << cfg_div system cycles. The first falling edge comes that many cycles after busy sets. sck_out is 1 whenever no transfer runs.
- R8: With the external clock (cfg_ext_clk=1), sck_oe is 0. Falling and rising edges on sck_in, after a two-flop synchroniser, move the data in the same way as in R3 and R4.
- R9: A start pulse or transmit-byte write while busy has no effect. The running transfer still makes exactly 8 bit exchanges and sends the byte loaded before start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| tx_wr | input | 1 | Write strobe for the transmit byte, ignored while busy |
| tx_byte | input | 8 | Transmit byte |
| start | input | 1 | Start pulse, ignored while busy |
| cfg_rx_only | input | 1 | 1 selects receive-only mode |
| cfg_lsb_first | input | 1 | 1 sends bit 0 first, 0 sends bit 7 first |
| cfg_ext_clk | input | 1 | 1 takes the shift clock from sck_in |
| cfg_div | input | SEL_W | Internal half-period select, DIV_BASE << cfg_div cycles |
| sck_in | input | 1 | Shift clock from an external master |
| si | input | 1 | Serial data in |
| sck_out | output | 1 | Internally generated shift clock |
| sck_oe | output | 1 | Drive enable for the clock pin |
| so | output | 1 | Serial data out |
| rx_data | output | 8 | Received byte, valid while not busy |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Set on completion, cleared by the next start |
| irq | output | 1 | One-cycle completion request |

## Verification
The bench uses DIV_BASE=2 and SEL_W=2, which gives half periods of 2 to 16 system cycles. It runs the shortest and the longest divider settings, so every internal half period can be timed exactly within a short run. In external-clock mode, the bench holds each sck_in level for eight system cycles, well above the synchroniser's three-cycle latency. This lets every data-out bit be read before the matching rising edge. Both bit orders, receive-only mode, and writes made during a transfer are each exercised against bytes chosen to be asymmetric, so that a reversed order or a frozen output shows up.

// File: rtl/serial_shift_port.sv
module serial_shift_port #(
  parameter int DIV_BASE = 2,
  parameter int SEL_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_wr,
  input  logic [7:0]       tx_byte,
  input  logic             start,
  input  logic             cfg_rx_only,
  input  logic             cfg_lsb_first,
  input  logic             cfg_ext_clk,
  input  logic [SEL_W-1:0] cfg_div,
  input  logic             sck_in,
  input  logic             si,
  output logic             sck_out,
  output logic             sck_oe,
  output logic             so,
  output logic [7:0]       rx_data,
  output logic             busy,
  output logic             done,
  output logic             irq
);
  localparam int MAXH = DIV_BASE << ((1 << SEL_W) - 1);
  localparam int TW   = $clog2(MAXH) + 1;

  logic [7:0]       shreg;
  logic [2:0]       cnt;
  logic [TW-1:0]    timer;
  logic [SEL_W-1:0] div_q;
  logic             busy_q, done_q, irq_q, sck_q, so_q;
  logic             ext_q, lsb_q, ro_q;
  logic             sync1, sync2, sprev;

  wire [TW-1:0] half_len = TW'(DIV_BASE) << div_q;
  wire tick    = busy_q && !ext_q && (timer == half_len - TW'(1));
  wire fall_ev = ext_q ? (busy_q && sprev && !sync2) : (tick && sck_q);
  wire rise_ev = ext_q ? (busy_q && !sprev && sync2) : (tick && !sck_q);
  wire last_ev = rise_ev && (cnt == 3'd7);
  wire go      = start && !busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b1;
      sync2 <= 1'b1;
      sprev <= 1'b1;
    end else begin
      sync1 <= sck_in;
      sync2 <= sync1;
      sprev <= sync2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q <= 1'b0;
      lsb_q <= 1'b0;
      ro_q  <= 1'b0;
      div_q <= '0;
    end else if (go) begin
      ext_q <= cfg_ext_clk;
      lsb_q <= cfg_lsb_first;
      ro_q  <= cfg_rx_only;
      div_q <= cfg_div;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      irq_q  <= 1'b0;
      cnt    <= '0;
    end else begin
      irq_q <= last_ev;
      if (go) begin
        busy_q <= 1'b1;
        done_q <= 1'b0;
        cnt    <= '0;
      end else if (rise_ev) begin
        cnt <= cnt + 3'd1;
        if (last_ev) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer <= '0;
      sck_q <= 1'b1;
    end else if (go || !busy_q) begin
      timer <= '0;
      sck_q <= 1'b1;
    end else if (tick) begin
      timer <= '0;
      sck_q <= !sck_q;
    end else if (!ext_q) begin
      timer <= timer + TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      so_q  <= 1'b0;
    end else begin
      if (tx_wr && !busy_q) shreg <= tx_byte;
      else if (rise_ev) shreg <= lsb_q ? {si, shreg[7:1]} : {shreg[6:0], si};
      if (fall_ev && !ro_q) so_q <= lsb_q ? shreg[0] : shreg[7];
    end
  end

  assign sck_out = sck_q;
  assign sck_oe  = !ext_q;
  assign so      = so_q;
  assign rx_data = shreg;
  assign busy    = busy_q;
  assign done    = done_q;
  assign irq     = irq_q;

  // R7
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> sck_q);

  // R2
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);

  // R2
  irq_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (done_q && !busy_q));

  // R2
  cnt_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (cnt == 3'd0));

  // R5
  so_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_q && !$stable(so_q)) |-> $fell(sck_q));

  // R6
  rx_only_so_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && ro_q && $past(busy_q)) |-> $stable(so_q));

  // R9
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start) |=> ($stable(div_q) && $stable(ext_q) && $stable(lsb_q)));
endmodule

// File: tb/test_serial_shift_port.sv
module test_serial_shift_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_wr = 1'b0, start = 1'b0;
  logic [7:0] tx_byte = '0;
  logic cfg_rx_only = 1'b0, cfg_lsb_first = 1'b0, cfg_ext_clk = 1'b0;
  logic [1:0] cfg_div = '0;
  logic sck_in = 1'b1, si = 1'b0;
  logic sck_out, sck_oe, so, busy, done, irq;
  logic [7:0] rx_data;
  int checks = 0, errs = 0, cyc = 0;

  always #5 clk = ~clk;

  serial_shift_port #(.DIV_BASE(2), .SEL_W(2)) i_serial_shift_port (
    .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_byte(tx_byte), .start(start),
    .cfg_rx_only(cfg_rx_only), .cfg_lsb_first(cfg_lsb_first),
    .cfg_ext_clk(cfg_ext_clk), .cfg_div(cfg_div), .sck_in(sck_in), .si(si),
    .sck_out(sck_out), .sck_oe(sck_oe), .so(so), .rx_data(rx_data),
    .busy(busy), .done(done), .irq(irq));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic begin_xfer(input [7:0] tx, input bit lsb, input bit ro,
                            input bit ext, input [1:0] d);
    @(negedge clk);
    cfg_lsb_first = lsb; cfg_rx_only = ro; cfg_ext_clk = ext; cfg_div = d;
    tx_wr = 1'b1; tx_byte = tx;
    @(negedge clk);
    tx_wr = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
    chk(done == 1'b0, "R2", "done cleared by start", int'(done), 0);
  endtask

  task automatic test_reset();
    chk(busy == 0 && done == 0 && irq == 0, "R1", "flags at reset",
        int'({busy, done, irq}), 0);
    chk(sck_out == 1 && sck_oe == 1, "R1", "clock pin at reset",
        int'({sck_out, sck_oe}), 3);
    chk(so == 0, "R1", "so at reset", int'(so), 0);
  endtask

  task automatic xfer_int(input [7:0] tx, input [7:0] rxp, input bit lsb,
                          input bit ro, input [1:0] d, input bit poke);
    int h = 2 << d;
    int gap = 0, falls = 0, rises = 0, bad_gap = 0, n = 0;
    bit prev = 1'b1, so0, so_moved = 1'b0, poked = 1'b0;
    logic [7:0] got = '0;
    so0 = so;
    begin_xfer(tx, lsb, ro, 1'b0, d);
    gap = 1;
    chk(sck_oe == 1, "R7", "sck_oe internal", int'(sck_oe), 1);
    while (busy && n < 1000) begin
      @(negedge clk);
      n++;
      tx_wr = 1'b0; start = 1'b0;
      if (sck_out != prev) begin
        if (gap != h) bad_gap++;
        gap = 0;
        if (!sck_out) begin
          int idx = lsb ? falls : 7 - falls;
          got[idx] = so;
          si = rxp[idx];
          falls++;
        end else rises++;
        prev = sck_out;
      end
      gap++;
      if (so != so0) so_moved = 1'b1;
      if (poke && falls == 3 && !poked) begin
        poked = 1'b1; tx_wr = 1'b1; tx_byte = ~tx; start = 1'b1;
      end
    end
    chk(bad_gap == 0, "R7", "half periods off", bad_gap, 0);
    chk(falls == 8 && rises == 8, poke ? "R9" : "R2", "edge count",
        falls * 16 + rises, 8 * 16 + 8);
    chk(irq == 1 && done == 1, "R2", "irq/done at end", int'({irq, done}), 3);
    if (ro) chk(!so_moved, "R6", "so moved in rx-only", int'(so_moved), 0);
    else chk(got == tx, lsb ? "R4" : "R3", "so bits", int'(got), int'(tx));
    chk(rx_data == rxp, lsb ? "R4" : "R3", "rx_data", int'(rx_data), int'(rxp));
    @(negedge clk);
    chk(irq == 0, "R2", "irq one cycle", int'(irq), 0);
    chk(sck_out == 1, "R7", "sck idle high", int'(sck_out), 1);
  endtask

  task automatic xfer_ext(input [7:0] tx, input [7:0] rxp, input bit lsb);
    logic [7:0] got = '0;
    begin_xfer(tx, lsb, 1'b0, 1'b1, 2'd0);
    chk(sck_oe == 0, "R8", "sck_oe external", int'(sck_oe), 0);
    for (int i = 0; i < 8; i++) begin
      int idx = lsb ? i : 7 - i;
      sck_in = 1'b0;
      repeat (8) @(negedge clk);
      got[idx] = so;
      si = rxp[idx];
      sck_in = 1'b1;
      repeat (8) @(negedge clk);
    end
    chk(got == tx, "R8", "ext so bits", int'(got), int'(tx));
    chk(rx_data == rxp, "R8", "ext rx_data", int'(rx_data), int'(rxp));
    chk(busy == 0 && done == 1, "R8", "ext completion", int'({busy, done}), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    xfer_int(8'hA3, 8'h5C, 1'b0, 1'b0, 2'd0, 1'b0);
    xfer_int(8'h1E, 8'hC4, 1'b1, 1'b0, 2'd3, 1'b0);
    xfer_int(8'hF0, 8'h37, 1'b0, 1'b1, 2'd1, 1'b0);
    xfer_int(8'h96, 8'h81, 1'b1, 1'b0, 2'd0, 1'b1);
    xfer_ext(8'hB2, 8'h4D, 1'b0);
    xfer_ext(8'h0D, 8'hE8, 1'b1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errs++; checks++;
        $display("FAIL watchdog: actual=%0d expected=0", cyc);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
      end
    end
  end
endmodule